// File: doc/BRIEF.md
# Send-DMA Engine Control Sequencer

This block decides what a send-DMA engine is allowed to do at any moment. It takes single-cycle event strobes from software and from the engine. It walks the engine through a fixed life cycle: powered down, waiting for start-up, idle, running, and a recovery path. The recovery path waits for the engine to halt, then for a hardware clean-up, then for a software clean-up, and then restarts. The block does not perform any clean-up itself. It only issues one-cycle request strobes to the agents that do the work, and it waits for their completion events.

A sticky run-intent flag records whether the engine should end up running or idle once start-up finishes. Go-running and go-idle events can therefore arrive while the machine waits in start-up or in a recovery state, and they are honoured later. The four engine control bits (enable, interrupt enable, halt, drain) are reloaded from a per-state parameter table every time the state register is written. Two debug outputs show the state before the most recent transition and the index of the most recently accepted event.

Top module: `dma_ctl_fsm`

## Requirements
- R1: After reset the machine is in the down state. The control nibble {drain,halt,intr_en,enable} is 0000, running and started are 0, all request strobes are 0, the previous-state output is 0 and the last-event output is 0.
- R2: Event bit indices, from highest to lowest priority, are: 0 go-down, 1 go-start, 2 hw-started, 3 go-running, 4 sw-cleaned, 5 hw-cleaned, 6 hw-halted, 7 go-idle, 8 error-halt-A, 9 error-halt-B. When several bits are set in one cycle, only the lowest index is acted on. The last-event output shows that index one cycle later.
- R3: State codes are: down 0, start-up-wait 1, idle 2, sw-clean-wait 3, hw-clean-wait 4, halt-wait 5, running 6. With the default table the control nibble for each state, in that order, is 0000, 0110, 0101, 0100, 1101, 1001, 0011. The previous-state output holds the code of the state that was left at the most recent transition.
- R4: In the down state, go-start and go-running both move to start-up-wait and set started. Go-running also sets the run intent.
- R5: In start-up-wait, hw-started moves to running if the run intent is set and to idle if it is not.
- R6: In start-up-wait, sw-clean-wait, hw-clean-wait and halt-wait, go-running sets the run intent and go-idle clears it, with no state change and no strobe.
- R7: In idle, go-running moves to running and sets the run intent. Go-down from idle or from start-up-wait moves to down and clears started.
- R8: In running, go-idle moves to halt-wait and clears the run intent. Error-halt-B moves to halt-wait and leaves the run intent unchanged.
- R9: In running, hw-halted and error-halt-A each move to sw-clean-wait and pulse the software clean-up request for one cycle.
- R10: In halt-wait, hw-halted moves to hw-clean-wait and pulses the hardware clean-up request. In hw-clean-wait, hw-cleaned moves to sw-clean-wait and pulses the software clean-up request.
- R11: In sw-clean-wait, sw-cleaned moves to start-up-wait and pulses the start-up request. Go-down from sw-clean-wait moves to down with no strobe.
- R12: Go-down from running, halt-wait or hw-clean-wait moves to down, pulses the software clean-up request and keeps started set. A later sw-cleaned in the down state clears started.
- R13: An event with no action in the current state changes no output: the state, the control bits and started stay as they were, and no strobe fires.
- R14: The running output is 1 exactly while the machine is in the running state. All outputs change on the clock edge that samples the event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ev | input | 10 | Event strobes, indices as in R2 |
| ctl_enable | output | 1 | Engine enable bit |
| ctl_intr_en | output | 1 | Engine interrupt enable bit |
| ctl_halt | output | 1 | Engine halt bit |
| ctl_drain | output | 1 | Engine drain bit |
| req_sw_clean | output | 1 | One-cycle software clean-up request |
| req_hw_clean | output | 1 | One-cycle hardware clean-up request |
| req_hw_start | output | 1 | One-cycle start-up request (disarm send buffers, restart engine) |
| running | output | 1 | High while in the running state |
| started | output | 1 | Machine-started reference flag |
| dbg_prev_state | output | 3 | State code left at the last transition |
| dbg_last_event | output | 4 | Index of the last accepted event |

## Verification
The bench takes the engine through error-halt-B and the full recovery path without any go-idle, and expects it to come back to running. A design that cleared the run intent on that error would stop in idle instead. Go-running is sent while the machine waits in halt-wait, so a design that dropped intent updates in waiting states would also fail to resume. Simultaneous go-down and go-running in idle must take the machine down; a wrong priority would leave it running. Go-down from running must keep started set until sw-cleaned arrives in the down state, so a design that released started too early is caught.

// File: rtl/dma_ctl_fsm.sv
module dma_ctl_fsm #(
  parameter int NUM_EV = 10,
  parameter logic [27:0] OUT_TABLE = {4'b0011, 4'b1001, 4'b1101, 4'b0100,
                                      4'b0101, 4'b0110, 4'b0000}
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_EV-1:0] ev,
  output logic              ctl_enable,
  output logic              ctl_intr_en,
  output logic              ctl_halt,
  output logic              ctl_drain,
  output logic              req_sw_clean,
  output logic              req_hw_clean,
  output logic              req_hw_start,
  output logic              running,
  output logic              started,
  output logic [2:0]        dbg_prev_state,
  output logic [3:0]        dbg_last_event
);
  localparam int EVW = 4;
  localparam logic [EVW-1:0] E_DOWN = 0, E_START = 1, E_HWSTARTED = 2,
    E_RUN = 3, E_SWCLEANED = 4, E_HWCLEANED = 5, E_HALTED = 6,
    E_IDLE = 7, E_ERR_A = 8, E_ERR_B = 9;

  typedef enum logic [2:0] {
    S_DOWN = 3'd0, S_STARTUP = 3'd1, S_IDLE = 3'd2, S_SWCLEAN = 3'd3,
    S_HWCLEAN = 3'd4, S_HALTWAIT = 3'd5, S_RUN = 3'd6
  } state_t;

  state_t st, nxt;
  logic intent, nintent, nstarted, nsw, nhw, nhs, vld;
  logic [EVW-1:0] e;
  logic [3:0] ctl;

  always_comb begin
    e = '0;
    for (int i = NUM_EV - 1; i >= 0; i--)
      if (ev[i]) e = EVW'(i);
  end
  assign vld = |ev;

  always_comb begin
    nxt = st;
    nintent = intent;
    nstarted = started;
    nsw = 1'b0;
    nhw = 1'b0;
    nhs = 1'b0;
    if (vld) begin
      case (st)
        S_DOWN: begin
          if (e == E_START || e == E_RUN) begin
            nxt = S_STARTUP;
            nstarted = 1'b1;
            if (e == E_RUN) nintent = 1'b1;
          end else if (e == E_SWCLEANED) nstarted = 1'b0;
        end
        S_STARTUP: begin
          if (e == E_DOWN) begin
            nxt = S_DOWN;
            nstarted = 1'b0;
          end else if (e == E_HWSTARTED) nxt = intent ? S_RUN : S_IDLE;
          else if (e == E_RUN) nintent = 1'b1;
          else if (e == E_IDLE) nintent = 1'b0;
        end
        S_IDLE: begin
          if (e == E_DOWN) begin
            nxt = S_DOWN;
            nstarted = 1'b0;
          end else if (e == E_RUN) begin
            nxt = S_RUN;
            nintent = 1'b1;
          end
        end
        S_SWCLEAN: begin
          if (e == E_DOWN) nxt = S_DOWN;
          else if (e == E_SWCLEANED) begin
            nxt = S_STARTUP;
            nhs = 1'b1;
          end else if (e == E_RUN) nintent = 1'b1;
          else if (e == E_IDLE) nintent = 1'b0;
        end
        S_HWCLEAN: begin
          if (e == E_DOWN) begin
            nxt = S_DOWN;
            nsw = 1'b1;
          end else if (e == E_HWCLEANED) begin
            nxt = S_SWCLEAN;
            nsw = 1'b1;
          end else if (e == E_RUN) nintent = 1'b1;
          else if (e == E_IDLE) nintent = 1'b0;
        end
        S_HALTWAIT: begin
          if (e == E_DOWN) begin
            nxt = S_DOWN;
            nsw = 1'b1;
          end else if (e == E_HALTED) begin
            nxt = S_HWCLEAN;
            nhw = 1'b1;
          end else if (e == E_RUN) nintent = 1'b1;
          else if (e == E_IDLE) nintent = 1'b0;
        end
        S_RUN: begin
          if (e == E_DOWN) begin
            nxt = S_DOWN;
            nsw = 1'b1;
          end else if (e == E_HALTED || e == E_ERR_A) begin
            nxt = S_SWCLEAN;
            nsw = 1'b1;
          end else if (e == E_IDLE) begin
            nxt = S_HALTWAIT;
            nintent = 1'b0;
          end else if (e == E_ERR_B) nxt = S_HALTWAIT;
        end
        default: nxt = S_DOWN;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_DOWN;
      intent <= 1'b0;
      started <= 1'b0;
      req_sw_clean <= 1'b0;
      req_hw_clean <= 1'b0;
      req_hw_start <= 1'b0;
      ctl <= OUT_TABLE[3:0];
      dbg_prev_state <= S_DOWN;
      dbg_last_event <= '0;
    end else begin
      st <= nxt;
      intent <= nintent;
      started <= nstarted;
      req_sw_clean <= nsw;
      req_hw_clean <= nhw;
      req_hw_start <= nhs;
      ctl <= OUT_TABLE[4*int'(nxt) +: 4];
      if (nxt != st) dbg_prev_state <= st;
      if (vld) dbg_last_event <= e;
    end
  end

  assign {ctl_drain, ctl_halt, ctl_intr_en, ctl_enable} = ctl;
  assign running = (st == S_RUN);
endmodule

// File: rtl/dma_ctl_fsm_chk.sv
module dma_ctl_fsm_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [9:0] ev,
  input logic       running,
  input logic       started,
  input logic       req_sw_clean,
  input logic       req_hw_clean,
  input logic       req_hw_start
);
  a_r9_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({req_sw_clean, req_hw_clean, req_hw_start}));

  a_r11_start_after_swclean: assert property (@(posedge clk) disable iff (!rst_n)
    req_hw_start |-> $past(ev[4]));

  a_r10_hwclean_not_running: assert property (@(posedge clk) disable iff (!rst_n)
    (req_hw_clean || req_sw_clean) |-> !running);

  a_r5_run_entry: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(running) |-> $past(ev[2] || ev[3]));

  a_r12_started_release: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(started) |-> $past(ev[0] || ev[4]));

  a_r4_started_set: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(started) |-> $past(ev[1] || ev[3]));
endmodule

bind dma_ctl_fsm dma_ctl_fsm_chk chk (
  .clk(clk), .rst_n(rst_n), .ev(ev), .running(running), .started(started),
  .req_sw_clean(req_sw_clean), .req_hw_clean(req_hw_clean),
  .req_hw_start(req_hw_start)
);

// File: tb/dma_ctl_fsm_test.sv
module dma_ctl_fsm_test;
  logic clk = 1'b0, rst_n = 1'b0;
  logic [9:0] ev = '0;
  logic en, ie, hl, dr, sw, hw, hs, run, stt;
  logic [2:0] prv;
  logic [3:0] lst;
  int checks = 0, fails = 0;

  localparam logic [3:0] C_DOWN = 4'b0000, C_STUP = 4'b0110, C_IDLE = 4'b0101,
    C_SWC = 4'b0100, C_HWC = 4'b1101, C_HALT = 4'b1001, C_RUN = 4'b0011;

  always #4 clk = ~clk;

  dma_ctl_fsm uut (
    .clk(clk), .rst_n(rst_n), .ev(ev), .ctl_enable(en), .ctl_intr_en(ie),
    .ctl_halt(hl), .ctl_drain(dr), .req_sw_clean(sw), .req_hw_clean(hw),
    .req_hw_start(hs), .running(run), .started(stt),
    .dbg_prev_state(prv), .dbg_last_event(lst)
  );

  task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic fire(logic [9:0] v);
    @(negedge clk) ev = v;
    @(negedge clk) ev = '0;
  endtask

  task automatic look(string req, logic [3:0] c, logic r, logic s,
                      logic [2:0] strb);
    chk(req, {12'd0, dr, hl, ie, en}, {12'd0, c});
    chk(req, {14'd0, run, stt}, {14'd0, r, s});
    chk(req, {13'd0, sw, hw, hs}, {13'd0, strb});
  endtask

  task automatic t_reset;
    look("R1", C_DOWN, 0, 0, 3'b000);
    chk("R1", {12'd0, prv, 1'b0}, 16'd0);
    chk("R1", {12'd0, lst}, 16'd0);
  endtask

  task automatic t_bringup_idle;
    fire(10'b1 << 1); look("R4", C_STUP, 0, 1, 3'b000);
    fire(10'b1 << 2); look("R5", C_IDLE, 0, 1, 3'b000);
    fire(10'b1 << 3); look("R7", C_RUN, 1, 1, 3'b000);
    chk("R3", {13'd0, prv}, 16'd2);
    chk("R2", {12'd0, lst}, 16'd3);
  endtask

  task automatic t_err_b_recovery;
    fire(10'b1 << 9); look("R8", C_HALT, 0, 1, 3'b000);
    fire(10'b1 << 6); look("R10", C_HWC, 0, 1, 3'b010);
    fire(10'b1 << 5); look("R10", C_SWC, 0, 1, 3'b100);
    fire(10'b1 << 4); look("R11", C_STUP, 0, 1, 3'b001);
    @(negedge clk); look("R11", C_STUP, 0, 1, 3'b000);
    fire(10'b1 << 2); look("R8", C_RUN, 1, 1, 3'b000);
  endtask

  task automatic t_idle_then_resume;
    fire(10'b1 << 7); look("R8", C_HALT, 0, 1, 3'b000);
    fire(10'b1 << 3); look("R6", C_HALT, 0, 1, 3'b000);
    fire(10'b1 << 6); look("R10", C_HWC, 0, 1, 3'b010);
    fire(10'b1 << 5); fire(10'b1 << 4);
    fire(10'b1 << 2); look("R6", C_RUN, 1, 1, 3'b000);
  endtask

  task automatic t_go_idle_lands_idle;
    fire(10'b1 << 7); fire(10'b1 << 6); fire(10'b1 << 5); fire(10'b1 << 4);
    fire(10'b1 << 2); look("R5", C_IDLE, 0, 1, 3'b000);
  endtask

  task automatic t_ignored;
    fire(10'b1 << 6); look("R13", C_IDLE, 0, 1, 3'b000);
    fire(10'b1 << 8); look("R13", C_IDLE, 0, 1, 3'b000);
    fire(10'b1 << 4); look("R13", C_IDLE, 0, 1, 3'b000);
  endtask

  task automatic t_priority;
    fire(10'b0000001001); look("R2", C_DOWN, 0, 0, 3'b000);
    chk("R2", {12'd0, lst}, 16'd0);
  endtask

  task automatic t_err_a_and_down;
    fire(10'b1 << 3); look("R4", C_STUP, 0, 1, 3'b000);
    fire(10'b1 << 2); look("R14", C_RUN, 1, 1, 3'b000);
    fire(10'b1 << 8); look("R9", C_SWC, 0, 1, 3'b100);
    fire(10'b1 << 0); look("R11", C_DOWN, 0, 1, 3'b000);
    fire(10'b1 << 4); look("R12", C_DOWN, 0, 0, 3'b000);
  endtask

  task automatic t_down_from_run;
    fire(10'b1 << 3); fire(10'b1 << 2); look("R4", C_RUN, 1, 1, 3'b000);
    fire(10'b1 << 6); look("R9", C_SWC, 0, 1, 3'b100);
    fire(10'b1 << 4); fire(10'b1 << 2); look("R14", C_RUN, 1, 1, 3'b000);
    fire(10'b1 << 0); look("R12", C_DOWN, 0, 1, 3'b100);
    chk("R3", {13'd0, prv}, 16'd6);
    fire(10'b1 << 4); look("R12", C_DOWN, 0, 0, 3'b000);
  endtask

  task automatic t_down_from_startup;
    fire(10'b1 << 1); fire(10'b1 << 0); look("R7", C_DOWN, 0, 0, 3'b000);
  endtask

  initial begin
    #(200000 * 8);
    fails++;
    $display("FAIL watchdog actual=%h expected=%h", 0, 1);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_bringup_idle();
    t_err_b_recovery();
    t_idle_then_resume();
    t_go_idle_lands_idle();
    t_ignored();
    t_priority();
    t_err_a_and_down();
    t_down_from_run();
    t_down_from_startup();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule